// File: doc/BRIEF.md
# Task-Level Handshake Channel

This block is a small scalar FIFO that joins two dataflow processes whose only contact with each other is a block-level handshake. The upstream process does not write on its own schedule. Instead, its completion pulse (`prod_done`) stores one scalar. The downstream process pops one scalar with its ready pulse (`cons_ready`), which it raises when it accepts a start. The channel maps these pulses directly onto the storage, so no per-iteration access strobes are involved.

Both sides behave like valid/ready pairs.

- **Producer side:** `prod_done` acts as the valid. `prod_cont` (not full) acts as the ready, and it drives the producer's continue input. While `prod_cont` is low, the producer is expected to stay in its finished state with `prod_done` and `prod_data` held. A done that the channel does not accept is dropped and must be presented again.
- **Consumer side:** `cons_start` (not empty) acts as the valid, and `cons_ready` acts as the ready. Data falls through, so `cons_data` already carries the oldest entry in every cycle that `cons_start` is high.

Storage depth is the parameter `DEPTH` (default 2). Reset is synchronous and active high.

Top module: `tlf_chan`

## Requirements
- R1: In a cycle where `prod_done` is high and `prod_cont` is high, `prod_data` is stored as one new entry at the rising edge. Each accepted pulse adds exactly one entry.
- R2: In a cycle where `cons_ready` and `cons_start` are both high, exactly one entry (the oldest) is removed at the rising edge.
- R3: When the channel is full, `prod_cont` is low. A `prod_done` in that cycle without `cons_ready` is ignored, and the stored contents stay as they were.
- R4: When the channel is empty, `cons_start` is low, and `cons_ready` has no effect.
- R5: Occupancy never exceeds `DEPTH`. `prod_cont` falls after exactly `DEPTH` accepted pushes with no pop.
- R6: When the channel is full, `prod_done` and `cons_ready` in the same cycle are both accepted, and it stays full. At partial occupancy, a simultaneous push and pop also leave the occupancy unchanged.
- R7: Whenever `cons_start` is high, `cons_data` shows the oldest entry. This holds from the first cycle after the edge that stored that entry.
- R8: Entries leave in the order they were accepted.
- R9: With `rst` high at a rising edge, the channel becomes empty: after that edge `cons_start` is 0 and `prod_cont` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_done | input | 1 | Producer completion pulse (push request) |
| prod_data | input | W | Scalar result of the producer run |
| prod_cont | output | 1 | Not full; drives the producer's continue |
| cons_ready | input | 1 | Consumer ready pulse (pop request) |
| cons_start | output | 1 | Not empty; drives the consumer's start |
| cons_data | output | W | Oldest stored scalar (fall-through) |

## Verification
`cons_start`, `prod_cont` and `cons_data` are all registered or read straight from registered state. Each therefore reflects a push or pop one rising edge after the cycle in which `prod_done` or `cons_ready` was presented.

The bench drives inputs on the falling edge. At the next falling edge, before it changes anything, it compares the outputs against a queue model that it has stepped once for that rising edge. Every check therefore falls exactly one edge after its stimulus.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
  // wrap a pointer at an arbitrary depth
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned d);
    return (p + 1 >= d) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/tlf_store.sv
module tlf_store #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && (waddr == PW'(i))) cells[i] <= wdata;
    end
  end

  always_comb begin
    rdata = cells[0];
    for (int i = 0; i < DEPTH; i++)
      if (raddr == PW'(i)) rdata = cells[i];
  end
endmodule

// File: rtl/tlf_ctrl.sv
module tlf_ctrl
  import tlf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          not_full,
  output logic          not_empty,
  output logic [CW-1:0] level
);
  logic          pop_ok;
  logic [CW-1:0] level_nx;

  assign pop_ok  = pop_req && not_empty;
  assign push_ok = push_req && (not_full || pop_ok);

  always_comb begin
    level_nx = level;
    if (push_ok && !pop_ok) level_nx = level + CW'(1);
    else if (pop_ok && !push_ok) level_nx = level - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      not_full  <= 1'b1;
      not_empty <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
      level     <= level_nx;
      not_full  <= (level_nx != CW'(DEPTH));
      not_empty <= (level_nx != '0);
    end
  end

  // R5: occupancy bounded
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  // R3: full with no pop ignores a push
  a_r3_full_hold: assert property (@(posedge clk) disable iff (rst)
    (!not_full && push_req && !pop_req) |=> ($stable(level) && $stable(wr_ptr)));
  // R4: empty ignores a pop
  a_r4_empty_idle: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && pop_req && !push_req) |=> ($stable(level) && $stable(rd_ptr)));
  // R6: full with both keeps full
  a_r6_full_both: assert property (@(posedge clk) disable iff (rst)
    (!not_full && push_req && pop_req) |=> !not_full);
  // R2: lone pop lowers the level by one
  a_r2_pop_one: assert property (@(posedge clk) disable iff (rst)
    (not_empty && pop_req && !push_req) |=> (level == $past(level) - CW'(1)));
endmodule

// File: rtl/tlf_chan.sv
module tlf_chan #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         prod_done,
  input  logic [W-1:0] prod_data,
  output logic         prod_cont,
  input  logic         cons_ready,
  output logic         cons_start,
  output logic [W-1:0] cons_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          we;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;

  tlf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_req(prod_done), .pop_req(cons_ready),
    .push_ok(we), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .not_full(prod_cont), .not_empty(cons_start), .level(level)
  );

  tlf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .waddr(wr_ptr), .wdata(prod_data),
    .raddr(rd_ptr), .rdata(cons_data)
  );

  // R9: reset leaves the channel empty
  a_r9_reset_empty: assert property (@(posedge clk)
    rst |=> (!cons_start && prod_cont));
  // R1: accepted push from empty raises start next cycle
  a_r1_push_start: assert property (@(posedge clk) disable iff (rst)
    (prod_done && !cons_start) |=> cons_start);
  // R5: flags never both low
  a_r5_flags: assert property (@(posedge clk) disable iff (rst)
    (prod_cont || cons_start));
endmodule

// File: tb/tlf_chan_test.sv
`timescale 1ns/1ps
module tlf_chan_test;
  localparam int W = 8;
  localparam int DEPTH = 2;

  logic clk = 0, rst = 1;
  logic prod_done = 0, cons_ready = 0;
  logic [W-1:0] prod_data = '0;
  logic prod_cont, cons_start;
  logic [W-1:0] cons_data;

  int tests = 0, fails = 0;
  logic [W-1:0] q[$];
  bit done_flag = 0;

  always #10 clk = ~clk; // 50 MHz

  tlf_chan #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .prod_done(prod_done), .prod_data(prod_data),
    .prod_cont(prod_cont), .cons_ready(cons_ready),
    .cons_start(cons_start), .cons_data(cons_data)
  );

  function automatic bit exp_cont(); return q.size() < DEPTH; endfunction
  function automatic bit exp_start(); return q.size() > 0; endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compare outputs (at negedge, state after last posedge)
  task automatic check_all(input string tag);
    check({tag, " R5 cont"}, W'(prod_cont), W'(exp_cont()));
    check({tag, " R4 start"}, W'(cons_start), W'(exp_start()));
    if (q.size() > 0) check({tag, " R7/R8 data"}, cons_data, q[0]);
  endtask

  // drive one cycle, step model, check after the edge
  task automatic step(input bit d, input logic [W-1:0] v, input bit r, input string tag);
    bit pop_ok, push_ok;
    prod_done = d; prod_data = v; cons_ready = r;
    pop_ok  = r && q.size() > 0;
    push_ok = d && (q.size() < DEPTH || pop_ok);
    @(posedge clk);
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(v);
    @(negedge clk);
    prod_done = 0; cons_ready = 0;
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 0;
    check_all("R9 reset");
    // R1/R7: single push appears next cycle
    step(1, 8'hA1, 0, "R1 push");
    // R5/R3: fill, then ignored push
    step(1, 8'hB2, 0, "R5 fill");
    step(1, 8'hC3, 0, "R3 full push ignored");
    // R6: full push+pop
    step(1, 8'hD4, 1, "R6 full both");
    // R2/R8: drain in order
    step(0, 0, 1, "R2 pop");
    step(0, 0, 1, "R2 pop last");
    // R4: empty pop ignored
    step(0, 0, 1, "R4 empty pop");
    // R6 partial: push then push+pop
    step(1, 8'h11, 0, "R1 push");
    step(1, 8'h22, 1, "R6 mid both");
    // R9: reset mid-stream
    rst = 1; @(posedge clk); q.delete(); @(negedge clk); rst = 0;
    check_all("R9 reset flush");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit d = ($urandom % 100) < 55;
      bit r = ($urandom % 100) < 45;
      step(d, W'($urandom), r, "R8 random");
    end
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule